// File: doc/BRIEF.md
# Downward Stack Pointer Unit

This block holds the 16-bit stack pointer of a small 8-bit processor core and turns the core's stack strobes into memory addresses and pointer updates. The stack grows toward lower addresses. A single-byte data push stores at the current pointer and then moves the pointer down by one. A data pop moves the pointer up by one and reads at the new location. A call or interrupt entry stores a two-byte return address and moves the pointer down by two. A return moves it up by two.

For each strobe the block drives two byte addresses in the same cycle. `addr_first` is the byte that is transferred first and `addr_second` is the byte that follows it. The pointer register takes its new value at the next rising clock edge. The SRAM and the data path that moves the bytes sit outside this block.

Software sees the pointer as two byte registers, a high byte and a low byte. It reads and writes them one byte at a time through a lane select. A software write in a cycle cancels any core update in that same cycle.

Top module: `stack_ptr_unit`

## Requirements
- R1: While reset is asserted, and after it is released, the pointer reads 0x0000, and both byte registers read 0x00.
- R2: A push strobe drives `addr_first` = `addr_second` = current pointer. The pointer is one lower after the clock edge.
- R3: A pop strobe drives `addr_first` = `addr_second` = current pointer + 1. The pointer is one higher after the clock edge.
- R4: A call strobe drives `addr_first` = current pointer, which is the slot for the return address low byte. It drives `addr_second` = current pointer − 1, which is the slot for the high byte. The pointer is two lower after the clock edge.
- R5: A return strobe drives `addr_first` = current pointer + 1, where the high byte is read. It drives `addr_second` = current pointer + 2, where the low byte is read. The pointer is two higher after the clock edge.
- R6: A software write with `sw_sel`=1 replaces pointer bits 15:8 and leaves bits 7:0 unchanged. A write with `sw_sel`=0 replaces bits 7:0 and leaves bits 15:8 unchanged.
- R7: `sw_rdata` shows pointer bits 15:8 when `sw_rd_sel`=1 and bits 7:0 when `sw_rd_sel`=0, in the same cycle.
- R8: When a software write and a core strobe come in the same cycle, only the software write changes the pointer. The strobe still drives its addresses.
- R9: When several strobes come together, only one is served, in this priority order: call, then return, then push, then pop.
- R10: With no strobe and no software write, the pointer holds its value and both addresses equal the pointer.
- R11: All pointer and address arithmetic wraps modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_req | input | 1 | Single-byte push strobe |
| pop_req | input | 1 | Single-byte pop strobe |
| call_req | input | 1 | Two-byte push strobe for call or interrupt entry |
| ret_req | input | 1 | Two-byte pop strobe for return |
| sw_wr_en | input | 1 | Software byte write enable |
| sw_sel | input | 1 | Write lane: 1 = high byte, 0 = low byte |
| sw_wdata | input | 8 | Software write data |
| sw_rd_sel | input | 1 | Read lane: 1 = high byte, 0 = low byte |
| sw_rdata | output | 8 | Selected pointer byte |
| addr_first | output | 16 | Address of the first byte of this cycle's access |
| addr_second | output | 16 | Address of the second byte (equals `addr_first` for one-byte accesses) |
| sp_out | output | 16 | Current pointer value |

## Verification
Two pairs of functions can fall in the same cycle.

- **Software write and core strobe.** The bench raises a byte write together with a push. It then checks two things: the push addresses are still driven from the old pointer, and after the edge the pointer carries the written byte with no decrement applied.
- **Two core strobes.** The bench raises call with return, push with pop, and return with push. Each result is judged against the priority rule: the addresses and the pointer step must be those of the winning strobe alone.

// File: rtl/stack_ptr_pkg.sv
package stack_ptr_pkg;
  typedef enum logic [2:0] {
    SP_IDLE = 3'd0,
    SP_PUSH = 3'd1,
    SP_POP  = 3'd2,
    SP_CALL = 3'd3,
    SP_RET  = 3'd4
  } sp_op_e;
endpackage

// File: rtl/sp_op_decode.sv
module sp_op_decode
  import stack_ptr_pkg::*;
(
  input  logic   call_req,
  input  logic   ret_req,
  input  logic   push_req,
  input  logic   pop_req,
  output sp_op_e op
);
  // Fixed priority: call, return, push, pop
  always_comb begin
    if (call_req)      op = SP_CALL;
    else if (ret_req)  op = SP_RET;
    else if (push_req) op = SP_PUSH;
    else if (pop_req)  op = SP_POP;
    else               op = SP_IDLE;
  end
endmodule

// File: rtl/sp_addr_gen.sv
module sp_addr_gen
  import stack_ptr_pkg::*;
#(
  parameter int PTR_W   = 16,
  parameter int RA_SIZE = 2
) (
  input  logic [PTR_W-1:0] sp_q,
  input  sp_op_e           op,
  output logic [PTR_W-1:0] addr_first,
  output logic [PTR_W-1:0] addr_second,
  output logic [PTR_W-1:0] core_next,
  output logic             core_upd
);
  localparam logic [PTR_W-1:0] STEP_DATA = PTR_W'(1);
  localparam logic [PTR_W-1:0] STEP_RA   = PTR_W'(RA_SIZE);

  logic [PTR_W-1:0] sp_up1;
  logic [PTR_W-1:0] sp_dn1;

  assign sp_up1 = sp_q + STEP_DATA;
  assign sp_dn1 = sp_q - STEP_DATA;

  always_comb begin
    addr_first  = sp_q;
    addr_second = sp_q;
    core_next   = sp_q;
    core_upd    = 1'b0;
    unique case (op)
      SP_PUSH: begin
        core_next = sp_dn1;
        core_upd  = 1'b1;
      end
      SP_POP: begin
        addr_first  = sp_up1;
        addr_second = sp_up1;
        core_next   = sp_up1;
        core_upd    = 1'b1;
      end
      SP_CALL: begin
        addr_second = sp_dn1;
        core_next   = sp_q - STEP_RA;
        core_upd    = 1'b1;
      end
      SP_RET: begin
        addr_first  = sp_up1;
        addr_second = sp_q + STEP_RA;
        core_next   = sp_q + STEP_RA;
        core_upd    = 1'b1;
      end
      default: begin
        core_upd = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/sp_reg_bank.sv
module sp_reg_bank #(
  parameter int PTR_W  = 16,
  parameter int BYTE_W = 8,
  localparam int LANES = PTR_W / BYTE_W,
  localparam int SEL_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_wr_en,
  input  logic [SEL_W-1:0]  sw_sel,
  input  logic [BYTE_W-1:0] sw_wdata,
  input  logic              core_upd,
  input  logic [PTR_W-1:0]  core_next,
  output logic [PTR_W-1:0]  sp_q
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [BYTE_W-1:0] lane_q;
    logic [BYTE_W-1:0] lane_d;
    logic              lane_en;

    // Software write wins over the core; a write to one lane freezes the other
    always_comb begin
      lane_en = 1'b0;
      lane_d  = lane_q;
      if (sw_wr_en) begin
        if (sw_sel == SEL_W'(g)) begin
          lane_en = 1'b1;
          lane_d  = sw_wdata;
        end
      end else if (core_upd) begin
        lane_en = 1'b1;
        lane_d  = core_next[g*BYTE_W +: BYTE_W];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lane_q <= '0;
      end else if (lane_en) begin
        lane_q <= lane_d;
      end
    end

    assign sp_q[g*BYTE_W +: BYTE_W] = lane_q;
  end
endmodule

// File: rtl/stack_ptr_unit.sv
module stack_ptr_unit
  import stack_ptr_pkg::*;
#(
  parameter int PTR_W   = 16,
  parameter int BYTE_W  = 8,
  parameter int RA_SIZE = 2
) (
  input  logic                                      clk,
  input  logic                                      rst_n,
  input  logic                                      push_req,
  input  logic                                      pop_req,
  input  logic                                      call_req,
  input  logic                                      ret_req,
  input  logic                                      sw_wr_en,
  input  logic [$clog2(PTR_W/BYTE_W)-1:0]           sw_sel,
  input  logic [BYTE_W-1:0]                         sw_wdata,
  input  logic [$clog2(PTR_W/BYTE_W)-1:0]           sw_rd_sel,
  output logic [BYTE_W-1:0]                         sw_rdata,
  output logic [PTR_W-1:0]                          addr_first,
  output logic [PTR_W-1:0]                          addr_second,
  output logic [PTR_W-1:0]                          sp_out
);
  sp_op_e           op;
  logic [PTR_W-1:0] sp_q;
  logic [PTR_W-1:0] core_next;
  logic             core_upd;

  sp_op_decode u_dec (
    .call_req (call_req),
    .ret_req  (ret_req),
    .push_req (push_req),
    .pop_req  (pop_req),
    .op       (op)
  );

  sp_addr_gen #(.PTR_W(PTR_W), .RA_SIZE(RA_SIZE)) u_agen (
    .sp_q        (sp_q),
    .op          (op),
    .addr_first  (addr_first),
    .addr_second (addr_second),
    .core_next   (core_next),
    .core_upd    (core_upd)
  );

  sp_reg_bank #(.PTR_W(PTR_W), .BYTE_W(BYTE_W)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .sw_wr_en  (sw_wr_en),
    .sw_sel    (sw_sel),
    .sw_wdata  (sw_wdata),
    .core_upd  (core_upd),
    .core_next (core_next),
    .sp_q      (sp_q)
  );

  assign sw_rdata = sp_q[sw_rd_sel*BYTE_W +: BYTE_W];
  assign sp_out   = sp_q;
endmodule

// File: rtl/stack_ptr_chk.sv
module stack_ptr_chk #(
  parameter int PTR_W  = 16,
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              push_req,
  input logic              pop_req,
  input logic              call_req,
  input logic              ret_req,
  input logic              sw_wr_en,
  input logic              sw_sel,
  input logic [BYTE_W-1:0] sw_wdata,
  input logic [PTR_W-1:0]  addr_first,
  input logic [PTR_W-1:0]  addr_second,
  input logic [PTR_W-1:0]  sp_out
);
  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  // R1
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reset_zero_chk: assert (sp_out == '0);
    end
  end

  // R2
  push_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && push_req && !call_req && !ret_req && !sw_wr_en)
      |=> sp_out == PTR_W'($past(sp_out) - PTR_W'(1)));

  // R3
  pop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && pop_req && !push_req && !call_req && !ret_req && !sw_wr_en)
      |=> sp_out == PTR_W'($past(sp_out) + PTR_W'(1)));

  // R4
  call_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && call_req && !sw_wr_en) |=> sp_out == PTR_W'($past(sp_out) - PTR_W'(2)));

  // R4
  call_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    call_req |-> (addr_first == sp_out) && (addr_second == PTR_W'(sp_out - PTR_W'(1))));

  // R5
  ret_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && ret_req && !call_req && !sw_wr_en) |=> sp_out == PTR_W'($past(sp_out) + PTR_W'(2)));

  // R8
  sw_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && sw_wr_en && sw_sel)
      |=> (sp_out[PTR_W-1 -: BYTE_W] == $past(sw_wdata)) &&
          (sp_out[BYTE_W-1:0] == $past(sp_out[BYTE_W-1:0])));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !push_req && !pop_req && !call_req && !ret_req && !sw_wr_en)
      |=> $stable(sp_out));
endmodule

bind stack_ptr_unit stack_ptr_chk #(.PTR_W(PTR_W), .BYTE_W(BYTE_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .push_req    (push_req),
  .pop_req     (pop_req),
  .call_req    (call_req),
  .ret_req     (ret_req),
  .sw_wr_en    (sw_wr_en),
  .sw_sel      (sw_sel[0]),
  .sw_wdata    (sw_wdata),
  .addr_first  (addr_first),
  .addr_second (addr_second),
  .sp_out      (sp_out)
);

// File: tb/stack_ptr_unit_tb.sv
module stack_ptr_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 13;

  typedef struct packed {
    logic        we;
    logic        hi;
    logic [7:0]  wd;
    logic [3:0]  ops;   // {call, ret, push, pop}
    logic [15:0] a0;
    logic [15:0] a1;
    logic [15:0] sp;
  } vec_t;

  // Starting from reset (pointer 0x0000)
  localparam vec_t VEC [NVEC] = '{
    '{1'b1, 1'b1, 8'h08, 4'b0000, 16'h0000, 16'h0000, 16'h0800}, // R6 high write
    '{1'b1, 1'b0, 8'h5F, 4'b0000, 16'h0800, 16'h0800, 16'h085F}, // R6 low write
    '{1'b0, 1'b0, 8'h00, 4'b0010, 16'h085F, 16'h085F, 16'h085E}, // R2 push
    '{1'b0, 1'b0, 8'h00, 4'b0010, 16'h085E, 16'h085E, 16'h085D}, // R2 push
    '{1'b0, 1'b0, 8'h00, 4'b1000, 16'h085D, 16'h085C, 16'h085B}, // R4 call
    '{1'b0, 1'b0, 8'h00, 4'b0100, 16'h085C, 16'h085D, 16'h085D}, // R5 return
    '{1'b0, 1'b0, 8'h00, 4'b0001, 16'h085E, 16'h085E, 16'h085E}, // R3 pop
    '{1'b0, 1'b0, 8'h00, 4'b0011, 16'h085E, 16'h085E, 16'h085D}, // R9 push over pop
    '{1'b0, 1'b0, 8'h00, 4'b1100, 16'h085D, 16'h085C, 16'h085B}, // R9 call over return
    '{1'b1, 1'b0, 8'h10, 4'b0010, 16'h085B, 16'h085B, 16'h0810}, // R8 write beats push
    '{1'b0, 1'b0, 8'h00, 4'b0000, 16'h0810, 16'h0810, 16'h0810}, // R10 idle
    '{1'b0, 1'b0, 8'h00, 4'b0110, 16'h0811, 16'h0812, 16'h0812}, // R9 return over push
    '{1'b0, 1'b0, 8'h00, 4'b0001, 16'h0813, 16'h0813, 16'h0813}  // R3 pop
  };

  function automatic string vec_tag(int i);
    case (i)
      0, 1:     return "R6";
      2, 3:     return "R2";
      4:        return "R4";
      5:        return "R5";
      6, 12:    return "R3";
      9:        return "R8";
      10:       return "R10";
      default:  return "R9";
    endcase
  endfunction

  logic        clk;
  logic        rst_n;
  logic        push_req, pop_req, call_req, ret_req;
  logic        sw_wr_en;
  logic [0:0]  sw_sel;
  logic [7:0]  sw_wdata;
  logic [0:0]  sw_rd_sel;
  logic [7:0]  sw_rdata;
  logic [15:0] addr_first, addr_second, sp_out;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  stack_ptr_unit dut_i (
    .clk(clk), .rst_n(rst_n),
    .push_req(push_req), .pop_req(pop_req), .call_req(call_req), .ret_req(ret_req),
    .sw_wr_en(sw_wr_en), .sw_sel(sw_sel), .sw_wdata(sw_wdata),
    .sw_rd_sel(sw_rd_sel), .sw_rdata(sw_rdata),
    .addr_first(addr_first), .addr_second(addr_second), .sp_out(sp_out)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string tag, string what, logic [15:0] act, logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    push_req = 0; pop_req = 0; call_req = 0; ret_req = 0;
    sw_wr_en = 0; sw_sel = 0; sw_wdata = 0;
  endtask

  // Drive at negedge; sample addresses 1 ns later; sample pointer 1 ns after posedge
  task automatic apply(logic we, logic hi, logic [7:0] wd, logic [3:0] ops,
                       logic [15:0] ea0, logic [15:0] ea1, logic [15:0] esp, string tag);
    @(negedge clk);
    sw_wr_en = we; sw_sel = hi; sw_wdata = wd;
    {call_req, ret_req, push_req, pop_req} = ops;
    #1;
    check(tag, "addr_first", addr_first, ea0);
    check(tag, "addr_second", addr_second, ea1);
    @(posedge clk);
    #1;
    check(tag, "pointer", sp_out, esp);
    idle_inputs();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    idle_inputs();
    sw_rd_sel = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check("R1", "pointer in reset", sp_out, 16'h0000);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    sw_rd_sel = 1; #1;
    check("R1", "high byte", {8'h00, sw_rdata}, 16'h0000);
    sw_rd_sel = 0; #1;
    check("R1", "low byte", {8'h00, sw_rdata}, 16'h0000);

    for (int i = 0; i < NVEC; i++) begin
      apply(VEC[i].we, VEC[i].hi, VEC[i].wd, VEC[i].ops,
            VEC[i].a0, VEC[i].a1, VEC[i].sp, vec_tag(i));
    end

    // R7 byte reads of pointer 0x0813
    @(negedge clk);
    sw_rd_sel = 1; #1;
    check("R7", "read high", {8'h00, sw_rdata}, 16'h0008);
    sw_rd_sel = 0; #1;
    check("R7", "read low", {8'h00, sw_rdata}, 16'h0013);

    // R11 wrap: pointer 0xFFFF, pop goes to 0x0000, call from 0x0001 wraps below zero
    apply(1, 1, 8'hFF, 4'b0000, 16'h0813, 16'h0813, 16'hFF13, "R11");
    apply(1, 0, 8'hFF, 4'b0000, 16'hFF13, 16'hFF13, 16'hFFFF, "R11");
    apply(0, 0, 8'h00, 4'b0001, 16'h0000, 16'h0000, 16'h0000, "R11");
    apply(0, 0, 8'h00, 4'b0001, 16'h0001, 16'h0001, 16'h0001, "R11");
    apply(0, 0, 8'h00, 4'b1000, 16'h0001, 16'h0000, 16'hFFFF, "R11");
    apply(0, 0, 8'h00, 4'b0100, 16'h0000, 16'h0001, 16'h0001, "R11");

    // R6 low write keeps high byte
    apply(1, 0, 8'hA5, 4'b0000, 16'h0001, 16'h0001, 16'h00A5, "R6");

    // R1 reset mid-run clears pointer
    @(negedge clk);
    rst_n = 0; #1;
    check("R1", "async reset", sp_out, 16'h0000);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1", "after release", sp_out, 16'h0000);

    finish_run();
  end
endmodule